// File: doc/BRIEF.md
# MMIO Address Range Router

This block takes the address of a memory-mapped I/O request and decides which of eight downstream ports should carry it. Two kinds of window are programmed through a plain 32-bit register bus. Four directed windows each send their whole address range to one port that software chooses. One distributed window is split into eight equal, consecutive slices, and each slice belongs to one port in address order. A directed window that matches overrides the distributed one.

A lookup is offered by raising `in_valid` with an address. Exactly one clock later, `out_valid` pulses for one cycle with the hit flag, the port number and the window kind. The result path has no back-pressure. The block takes a new address every cycle, and the consumer must accept each result in the cycle it is presented. Register writes take effect at the clock edge that performs them. A lookup sampled at that same edge still sees the old settings.

Top module: `mmio_range_router`

## Requirements
- R1: After reset, every register reads 0, every window is disabled, and `out_valid`, `out_hit`, `out_port` and `out_directed` are all 0.
- R2: Register offsets: directed window i has its base at 0x300+0x18*i, its mask at 0x308+0x18*i and its route at 0x310+0x18*i, for i = 0..3. The distributed window has its base at 0x360, its mask at 0x368 and its route at 0x370. `reg_rdata` shows the full 32-bit value stored at `reg_addr` in the same cycle, and any other offset reads 0.
- R3: Bit 0 of a base register enables the window. A window whose bit 0 is 0 never matches, and the window start is the base with bit 0 cleared.
- R4: A window covers every address from its start to start + (~mask), with both ends included. The address one below the start and the address one above the end do not match.
- R5: When a directed window matches, the result is hit=1, directed=1 and port = bits [2:0] of that window's route register.
- R6: A matching directed window wins over the distributed window. When several directed windows match, the one with the lowest index wins.
- R7: In the distributed window, span = floor((~mask)/8). Port n owns offsets n*(span+1) through n*(span+1)+span, measured from the window start. The result has hit=1 and directed=0, and any offset beyond ~mask misses.
- R8: When no enabled window matches, the result is hit=0, port=0 and directed=0.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R10: A lookup presented in the same cycle as a register write is decoded with the register values from before that write.
- R11: The distributed route register is stored and reads back, but it has no effect on any decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` (combinational) |
| in_valid | input | 1 | Lookup request strobe |
| in_addr | input | 32 | Address to decode |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_hit | output | 1 | An enabled window matched |
| out_port | output | 3 | Selected downstream port |
| out_directed | output | 1 | 1 = directed window matched, 0 = distributed window or miss |

## Verification
Directed lookups probe each window's first and last address and the addresses just outside them. They also probe overlapping directed windows, a directed window placed inside a distributed slice, and a distributed window whose length is not a multiple of eight. Together these separate an off-by-one at either edge, a wrong priority order and wrong slice arithmetic. Seeded random configurations mix enabled and disabled windows with masks of random width. The random addresses fall around window edges, so the comparisons with the bench model cover overlap and wrap cases that the directed lookups miss. Register readback, a write that coincides with a lookup, and writes to the distributed route register check that the storage and its timing are kept apart from the decode path.

// File: rtl/mmio_route_pkg.sv
package mmio_route_pkg;
  // register byte offsets; directed windows repeat at DIR_STRIDE
  localparam int unsigned DIR0_BASE_OFS  = 'h300;
  localparam int unsigned DIR0_MASK_OFS  = 'h308;
  localparam int unsigned DIR0_ROUTE_OFS = 'h310;
  localparam int unsigned DIR_STRIDE     = 'h018;
  localparam int unsigned DIST_BASE_OFS  = 'h360;
  localparam int unsigned DIST_MASK_OFS  = 'h368;
  localparam int unsigned DIST_ROUTE_OFS = 'h370;
endpackage

// File: rtl/mmio_route_regs.sv
module mmio_route_regs
  import mmio_route_pkg::*;
#(
  parameter int NUM_DIR = 4,
  parameter int DW      = 32,
  parameter int RA_W    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [RA_W-1:0]               reg_addr,
  input  logic [DW-1:0]                 reg_wdata,
  output logic [DW-1:0]                 reg_rdata,
  output logic [NUM_DIR-1:0][DW-1:0]    dir_base,
  output logic [NUM_DIR-1:0][DW-1:0]    dir_mask,
  output logic [NUM_DIR-1:0][DW-1:0]    dir_route,
  output logic [DW-1:0]                 dist_base,
  output logic [DW-1:0]                 dist_mask,
  output logic [DW-1:0]                 dist_route
);
  localparam logic [RA_W-1:0] DB_OFS = RA_W'(DIST_BASE_OFS);
  localparam logic [RA_W-1:0] DM_OFS = RA_W'(DIST_MASK_OFS);
  localparam logic [RA_W-1:0] DR_OFS = RA_W'(DIST_ROUTE_OFS);

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    localparam logic [RA_W-1:0] B_OFS = RA_W'(DIR0_BASE_OFS + g * DIR_STRIDE);
    localparam logic [RA_W-1:0] M_OFS = RA_W'(DIR0_MASK_OFS + g * DIR_STRIDE);
    localparam logic [RA_W-1:0] R_OFS = RA_W'(DIR0_ROUTE_OFS + g * DIR_STRIDE);
    logic [DW-1:0] base_q, mask_q, route_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q  <= '0;
        mask_q  <= '0;
        route_q <= '0;
      end else if (reg_we) begin
        if (reg_addr == B_OFS) base_q  <= reg_wdata;
        if (reg_addr == M_OFS) mask_q  <= reg_wdata;
        if (reg_addr == R_OFS) route_q <= reg_wdata;
      end
    end

    assign dir_base[g]  = base_q;
    assign dir_mask[g]  = mask_q;
    assign dir_route[g] = route_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_base  <= '0;
      dist_mask  <= '0;
      dist_route <= '0;
    end else if (reg_we) begin
      if (reg_addr == DB_OFS) dist_base  <= reg_wdata;
      if (reg_addr == DM_OFS) dist_mask  <= reg_wdata;
      if (reg_addr == DR_OFS) dist_route <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_DIR; i++) begin
      if (reg_addr == RA_W'(DIR0_BASE_OFS + i * DIR_STRIDE))  reg_rdata = dir_base[i];
      if (reg_addr == RA_W'(DIR0_MASK_OFS + i * DIR_STRIDE))  reg_rdata = dir_mask[i];
      if (reg_addr == RA_W'(DIR0_ROUTE_OFS + i * DIR_STRIDE)) reg_rdata = dir_route[i];
    end
    if (reg_addr == DB_OFS) reg_rdata = dist_base;
    if (reg_addr == DM_OFS) reg_rdata = dist_mask;
    if (reg_addr == DR_OFS) reg_rdata = dist_route;
  end
endmodule

// File: rtl/mmio_window_match.sv
module mmio_window_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  output logic          hit,
  output logic [AW-1:0] offset,
  output logic [AW-1:0] len
);
  logic [AW-1:0] start;

  // bit 0 of base is the enable; the start is always even
  assign start  = {base[AW-1:1], 1'b0};
  assign len    = ~mask;
  assign offset = addr - start;
  assign hit    = base[0] && (addr >= start) && (offset <= len);
endmodule

// File: rtl/mmio_slice_pick.sv
module mmio_slice_pick #(
  parameter int AW        = 32,
  parameter int NUM_PORTS = 8
) (
  input  logic [AW-1:0]                  offset,
  input  logic [AW-1:0]                  len,
  output logic                           found,
  output logic [$clog2(NUM_PORTS)-1:0]   port
);
  localparam int PW = $clog2(NUM_PORTS);
  localparam int WW = AW + PW + 1;

  logic [WW-1:0]        span_w, step_w, off_w;
  logic [NUM_PORTS-1:0] in_slice;

  assign span_w = WW'(len / AW'(NUM_PORTS));
  assign step_w = span_w + WW'(1);
  assign off_w  = WW'(offset);

  for (genvar n = 0; n < NUM_PORTS; n++) begin : g_slice
    logic [WW-1:0] lo;
    assign lo          = WW'(n) * step_w;
    assign in_slice[n] = (off_w >= lo) && (off_w <= lo + span_w);
  end

  always_comb begin
    found = |in_slice;
    port  = '0;
    for (int n = NUM_PORTS - 1; n >= 0; n--) begin
      if (in_slice[n]) port = PW'(n);
    end
  end
endmodule

// File: rtl/mmio_range_router.sv
module mmio_range_router #(
  parameter int NUM_DIR   = 4,
  parameter int NUM_PORTS = 8,
  parameter int ADDR_W    = 32,
  parameter int REG_AW    = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [ADDR_W-1:0]             reg_wdata,
  output logic [ADDR_W-1:0]             reg_rdata,
  input  logic                          in_valid,
  input  logic [ADDR_W-1:0]             in_addr,
  output logic                          out_valid,
  output logic                          out_hit,
  output logic [$clog2(NUM_PORTS)-1:0]  out_port,
  output logic                          out_directed
);
  localparam int PORT_W = $clog2(NUM_PORTS);

  logic [NUM_DIR-1:0][ADDR_W-1:0] dir_base, dir_mask, dir_route;
  logic [ADDR_W-1:0]              dist_base, dist_mask, dist_route;

  mmio_route_regs #(.NUM_DIR(NUM_DIR), .DW(ADDR_W), .RA_W(REG_AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dir_base  (dir_base),
    .dir_mask  (dir_mask),
    .dir_route (dir_route),
    .dist_base (dist_base),
    .dist_mask (dist_mask),
    .dist_route(dist_route)
  );

  logic [NUM_DIR-1:0] dir_hit;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dwin
    logic [ADDR_W-1:0] off_unused, len_unused;
    mmio_window_match #(.AW(ADDR_W)) u_match (
      .addr  (in_addr),
      .base  (dir_base[g]),
      .mask  (dir_mask[g]),
      .hit   (dir_hit[g]),
      .offset(off_unused),
      .len   (len_unused)
    );
  end

  logic              dist_in;
  logic [ADDR_W-1:0] dist_off, dist_len;
  logic              slice_found;
  logic [PORT_W-1:0] slice_port;

  mmio_window_match #(.AW(ADDR_W)) u_dist_match (
    .addr  (in_addr),
    .base  (dist_base),
    .mask  (dist_mask),
    .hit   (dist_in),
    .offset(dist_off),
    .len   (dist_len)
  );

  mmio_slice_pick #(.AW(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_slice (
    .offset(dist_off),
    .len   (dist_len),
    .found (slice_found),
    .port  (slice_port)
  );

  logic              nxt_hit, nxt_dir;
  logic [PORT_W-1:0] nxt_port;

  // distributed first, then directed windows from highest to lowest index
  always_comb begin
    nxt_hit  = 1'b0;
    nxt_dir  = 1'b0;
    nxt_port = '0;
    if (dist_in && slice_found) begin
      nxt_hit  = 1'b1;
      nxt_port = slice_port;
    end
    for (int i = NUM_DIR - 1; i >= 0; i--) begin
      if (dir_hit[i]) begin
        nxt_hit  = 1'b1;
        nxt_dir  = 1'b1;
        nxt_port = dir_route[i][PORT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_hit      <= 1'b0;
      out_port     <= '0;
      out_directed <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit      <= nxt_hit;
        out_port     <= nxt_port;
        out_directed <= nxt_dir;
      end
    end
  end
endmodule

// File: rtl/mmio_range_router_chk.sv
module mmio_range_router_chk #(
  parameter int NUM_DIR = 4,
  parameter int ADDR_W  = 32,
  parameter int PORT_W  = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       out_valid,
  input logic                       out_hit,
  input logic [PORT_W-1:0]          out_port,
  input logic                       out_directed,
  input logic [NUM_DIR-1:0][ADDR_W-1:0] dir_base,
  input logic [ADDR_W-1:0]          dist_base
);
  logic any_en;
  always_comb begin
    any_en = dist_base[0];
    for (int i = 0; i < NUM_DIR; i++) any_en = any_en | dir_base[i][0];
  end

  a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_miss_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_port == '0 && !out_directed));

  a_r5_directed_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_directed |-> out_hit);

  a_r3_all_disabled_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_en) |=> !out_hit);
endmodule

bind mmio_range_router mmio_range_router_chk #(
  .NUM_DIR(NUM_DIR), .ADDR_W(ADDR_W), .PORT_W(PORT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_hit     (out_hit),
  .out_port    (out_port),
  .out_directed(out_directed),
  .dir_base    (dir_base),
  .dist_base   (dist_base)
);

// File: tb/mmio_range_router_tb.sv
`timescale 1ns/1ps
module mmio_range_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid, out_hit, out_directed;
  logic [2:0]  out_port;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] sh_b[4], sh_m[4], sh_r[4];
  logic [31:0] sh_db, sh_dm, sh_dr;

  always #10 clk = ~clk;

  mmio_range_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
    .out_port(out_port), .out_directed(out_directed)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(reg_rdata == exp, req, "readback", reg_rdata, exp);
  endtask

  task automatic set_dir(input int i, input logic [31:0] b, input logic [31:0] m, input logic [31:0] r);
    wr(12'(12'h300 + i * 12'h18), b);
    wr(12'(12'h308 + i * 12'h18), m);
    wr(12'(12'h310 + i * 12'h18), r);
    sh_b[i] = b; sh_m[i] = m; sh_r[i] = r;
  endtask

  task automatic set_dist(input logic [31:0] b, input logic [31:0] m, input logic [31:0] r);
    wr(12'h360, b); wr(12'h368, m); wr(12'h370, r);
    sh_db = b; sh_dm = m; sh_dr = r;
  endtask

  // reference decode written from the requirements
  function automatic void model(input logic [31:0] a, output logic eh,
                                output logic [2:0] ep, output logic ed);
    longint unsigned st, ln, sp, lo;
    logic [31:0] inv;
    eh = 0; ep = 0; ed = 0;
    for (int i = 0; i < 4; i++) begin
      if (!eh && sh_b[i][0]) begin
        st = {sh_b[i][31:1], 1'b0};
        inv = ~sh_m[i]; ln = inv;
        if (a >= st && a <= st + ln) begin
          eh = 1; ed = 1; ep = sh_r[i][2:0];
        end
      end
    end
    if (!eh && sh_db[0]) begin
      st = {sh_db[31:1], 1'b0};
      inv = ~sh_dm; ln = inv;
      if (a >= st && a <= st + ln) begin
        sp = ln / 8;
        for (int n = 0; n < 8; n++) begin
          lo = st + longint'(n) * (sp + 1);
          if (!eh && a >= lo && a <= lo + sp) begin
            eh = 1; ep = 3'(n);
          end
        end
      end
    end
  endfunction

  task automatic look(input logic [31:0] a, input string req);
    logic eh, ed;
    logic [2:0] ep;
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    model(a, eh, ep, ed);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, req, "valid", 32'(out_valid), 32'd1);
    check(out_hit == eh && out_port == ep && out_directed == ed, req,
          $sformatf("result@%08h {hit,dir,port}", a),
          {27'd0, out_hit, out_directed, out_port}, {27'd0, eh, ed, ep});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] tgt, ln;
    logic eh, ed;
    logic [2:0] ep;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin sh_b[i] = 0; sh_m[i] = 0; sh_r[i] = 0; end
    sh_db = 0; sh_dm = 0; sh_dr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    check(!out_valid && !out_hit && out_port == 0 && !out_directed, "R1", "outputs",
          {28'd0, out_valid, out_hit, out_directed, |out_port}, 32'd0);
    rd_check(12'h300, 32'd0, "R1");
    rd_check(12'h368, 32'd0, "R1");
    look(32'h0000_0000, "R1");
    look(32'hFFFF_FFFE, "R8");

    // R2 register map and readback
    for (int i = 0; i < 4; i++)
      set_dir(i, 32'h1100_0000 * (i + 1) & 32'hFFFF_FFFE, 32'hA5A5_0000 + 32'(i), 32'h5A00_0010 + 32'(i));
    set_dist(32'h3300_0000, 32'hC3C3_0000, 32'h7700_0007);
    for (int i = 0; i < 4; i++) begin
      rd_check(12'(12'h300 + i * 12'h18), sh_b[i], "R2");
      rd_check(12'(12'h308 + i * 12'h18), sh_m[i], "R2");
      rd_check(12'(12'h310 + i * 12'h18), sh_r[i], "R2");
    end
    rd_check(12'h360, sh_db, "R2");
    rd_check(12'h368, sh_dm, "R2");
    rd_check(12'h370, sh_dr, "R2");
    rd_check(12'h304, 32'd0, "R2");
    rd_check(12'h37C, 32'd0, "R2");
    look(32'h1100_0000, "R3");   // base stored but disabled

    // directed window 0: 0x80000000..0x8000FFFF -> port 5
    set_dir(0, 32'h8000_0001, 32'hFFFF_0000, 32'hFFFF_FFF5);
    set_dir(1, 32'h9000_0000, 32'hFFFF_0000, 32'h0000_0003);
    set_dir(2, 32'h8000_8001, 32'hFFFF_F000, 32'h0000_0002);
    set_dir(3, 32'hA200_0001, 32'hFFFF_FF00, 32'h0000_0006);
    look(32'h8000_0000, "R4");
    look(32'h8000_FFFF, "R4");
    look(32'h8001_0000, "R4");
    look(32'h7FFF_FFFF, "R4");
    look(32'h8000_1234, "R5");
    look(32'h9000_0010, "R3");
    look(32'h8000_8010, "R6");   // overlap: window 0 wins over window 2

    // distributed window 0xA0000000..0xAFFFFFFF, slices of 0x02000000
    set_dist(32'hA000_0001, 32'hF000_0000, 32'h0000_0005);
    look(32'hA000_0000, "R7");
    look(32'hA1FF_FFFF, "R7");
    look(32'hA600_0000, "R7");
    look(32'hAFFF_FFFF, "R7");
    look(32'hB000_0000, "R8");
    look(32'hA200_0080, "R6");   // directed window 3 inside slice 1
    look(32'hA200_0100, "R7");

    // odd length: ~mask = 0x63, span 12
    set_dist(32'h1000_0001, 32'hFFFF_FF9C, 32'h0);
    look(32'h1000_000C, "R7");
    look(32'h1000_000D, "R7");
    look(32'h1000_0063, "R7");
    look(32'h1000_0064, "R7");

    // R11 distributed route has no effect
    set_dist(32'h1000_0001, 32'hFFFF_FF9C, 32'hFFFF_FFFF);
    rd_check(12'h370, 32'hFFFF_FFFF, "R11");
    look(32'h1000_0020, "R11");
    look(32'h1000_000D, "R11");

    // R10 write coinciding with a lookup uses the old values
    @(negedge clk);
    in_valid = 1'b1; in_addr = 32'h8000_0010;
    reg_we = 1'b1; reg_addr = 12'h300; reg_wdata = 32'h0;
    model(32'h8000_0010, eh, ep, ed);
    @(negedge clk);
    in_valid = 1'b0; reg_we = 1'b0;
    sh_b[0] = 32'h0;
    check(out_valid && out_hit == eh && out_port == ep && out_directed == ed, "R10",
          "result during write", {28'd0, out_valid, out_hit, out_directed, out_port[0]},
          {28'd0, 1'b1, eh, ed, ep[0]});
    look(32'h8000_0010, "R10");

    // R9 valid drops when idle
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "idle valid", 32'(out_valid), 32'd0);
    look(32'h8000_8020, "R9");

    // random configurations
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int i = 0; i < 4; i++) begin
        int k;
        k = $urandom_range(4, 20);
        set_dir(i, ($urandom & 32'hFFFF_F000) | 32'(($urandom % 4) != 0),
                ($urandom % 3 == 0) ? ($urandom | 32'hFFFF_0000) : ~((32'd1 << k) - 32'd1),
                $urandom);
      end
      set_dist(($urandom & 32'hFF00_0000) | 32'(($urandom % 5) != 0),
               ~((32'd1 << $urandom_range(8, 24)) - 32'd1), $urandom);
      for (int t = 0; t < 60; t++) begin
        int w;
        w = $urandom_range(0, 4);
        if (w == 4) begin tgt = {sh_db[31:1], 1'b0}; ln = ~sh_dm; end
        else begin tgt = {sh_b[w][31:1], 1'b0}; ln = ~sh_m[w]; end
        case ($urandom % 4)
          0: tgt = tgt + ln;
          1: tgt = tgt + ln + 32'd1;
          2: tgt = tgt - 32'd1;
          default: tgt = tgt + ($urandom % (ln + 32'd1));
        endcase
        look(tgt, "R7");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule